// File: doc/BRIEF.md
# Static Slot Transmit Arbiter

This block decides, at the start of every static slot of a time-triggered communication cycle, which transmit buffer goes out on each channel. It keeps a small table of transmit buffers. Each entry holds the slot it belongs to, a cycle filter (base and mask), a per-channel enable, a repeat/single-shot type, and four state flags: lock, commit, valid and full. A slot timer outside the block supplies the slot number, the cycle count and a slot-start strobe. A frame engine outside the block reports the end of each transmission with one done strobe per channel. Serialization, line coding and the dynamic segment belong to other blocks.

The host reaches the table through a one-operation-per-cycle command port. A buffer must be locked before its configuration can be written or it can be committed. Unlocking a committed buffer makes it valid, which makes it eligible for arbitration. While a committed buffer is valid, the host cannot lock it again until the frame has gone out at least once. For each channel the block registers a grant: a valid bit and the index of the winning buffer. The grant holds until that channel reports done or the next slot starts.

Top module: `slot_tx_arbiter`

## Requirements
- R1: Only buffers whose valid flag is 1 and whose lock flag is 0 may be granted; a locked buffer is excluded even when otherwise matching.
- R2: A buffer is a candidate for channel c only if its slot field equals slotNum, (cycleCnt & mask) equals (base & mask), and bit c of its channel enable is 1.
- R3: Among the candidates for one channel, the lowest buffer index wins, decided separately for each channel, so a buffer enabled on both channels may be granted on both in the same slot.
- R4: On a cycle with slotStart high, grantValid[c] and grantIdx bits [c*IDX_W +: IDX_W] take the arbitration result at that clock edge (grantValid low if there is no candidate). The grant then holds until a txDone[c] edge, which clears grantValid[c], or the next slotStart.
- R5: Command code 1 (lock) sets the lock flag unless the buffer is both valid and committed, in which case the request is refused. The lock flag is the acknowledge. Code 3 (commit) and code 5 (configuration write from the cfg* inputs) take effect only on a locked buffer. Code 0 does nothing.
- R6: Command code 2 (unlock) on a locked buffer clears the lock flag, and it sets the valid flag if the commit flag was 1 before that edge.
- R7: A txDone[c] edge while grantValid[c] is high sets the full flag of the granted buffer and clears its commit flag. It also clears its valid flag when the type bit is 0; with type 1 valid stays set.
- R8: When a done and a host command hit the same buffer at the same edge, the done is applied first and the host command second, except that the full flag set by the done wins over a host clear (code 4).
- R9: Command code 4 clears the full flag. After reset all flags, grants and configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostOp | input | 3 | Host command: 0 idle, 1 lock, 2 unlock, 3 commit, 4 clear full, 5 write configuration |
| hostIdx | input | IDX_W | Buffer addressed by the host command |
| cfgSlot | input | SLOT_W | Slot number written by command 5 |
| cfgCycBase | input | CYC_W | Cycle filter base written by command 5 |
| cfgCycMask | input | CYC_W | Cycle filter mask written by command 5 (1 = compared bit) |
| cfgChan | input | NUM_CH | Channel enables written by command 5 |
| cfgRepeat | input | 1 | Type bit written by command 5 (1 = stays valid after sending) |
| slotStart | input | 1 | Start of a static slot |
| slotNum | input | SLOT_W | Current static slot number |
| cycleCnt | input | CYC_W | Current cycle count |
| txDone | input | NUM_CH | One per channel: transmission of the granted frame finished |
| grantValid | output | NUM_CH | One per channel: a buffer is granted |
| grantIdx | output | NUM_CH*IDX_W | Granted buffer index, channel c at bits [c*IDX_W +: IDX_W] |
| lockFlags | output | NUM_BUF | Lock flag per buffer (lock acknowledge) |
| commitFlags | output | NUM_BUF | Commit flag per buffer |
| validFlags | output | NUM_BUF | Valid flag per buffer |
| fullFlags | output | NUM_BUF | Full flag per buffer |

## Verification
A transmission finishing and a host command can land on the same buffer in the same cycle, and this is where the two halves of the block disagree. The bench provokes it by raising txDone on a channel in the same cycle that the granted buffer receives a clear-full or a commit command. It then judges the flags after that edge against R8: full must stay set, and the host's new commit must survive the commit clear that the done applies. An exhaustive sweep of every slot and cycle value on a four-buffer table covers the arbitration itself: it exercises lowest-index ties, a buffer granted on both channels, and single-shot buffers that drop out after their first send.

// File: rtl/sta_pkg.sv
package sta_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LOCK    = 3'd1,
    OP_UNLOCK  = 3'd2,
    OP_COMMIT  = 3'd3,
    OP_CLRFULL = 3'd4,
    OP_CONFIG  = 3'd5
  } hostOp_e;

  // Accepted host actions, already gated by buffer state.
  typedef struct packed {
    logic lockGo;
    logic unlockGo;
    logic commitGo;
    logic clrFullGo;
    logic cfgGo;
  } hostStb_t;

endpackage

// File: rtl/sta_pick.sv
module sta_pick #(
  parameter int NUM_BUF = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_BUF-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   pick
);

  // Lowest set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    found = |cand;
    pick  = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (cand[i]) pick = IDX_W'(i);
    end
  end

endmodule

// File: rtl/sta_ctrl.sv
module sta_ctrl
  import sta_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int NUM_CH  = 2,
  parameter int IDX_W   = 2
) (
  input  logic [2:0]         hostOp,
  input  logic [IDX_W-1:0]   hostIdx,
  input  logic [NUM_BUF-1:0] lockFlags,
  input  logic [NUM_BUF-1:0] validFlags,
  input  logic [NUM_BUF-1:0] commitFlags,
  input  logic [NUM_CH-1:0]  grantValid,
  input  logic [NUM_CH-1:0]  txDone,
  output hostStb_t           stb,
  output logic [NUM_CH-1:0]  doneGo
);

  logic idxOk;
  logic selLock;
  logic selValid;
  logic selCommit;
  logic pinned;

  assign idxOk = (32'(hostIdx) < NUM_BUF);

  always_comb begin
    selLock   = 1'b0;
    selValid  = 1'b0;
    selCommit = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (hostIdx == IDX_W'(i)) begin
        selLock   = lockFlags[i];
        selValid  = validFlags[i];
        selCommit = commitFlags[i];
      end
    end
  end

  // A committed frame waiting to go out cannot be pulled back by a lock.
  assign pinned = selValid & selCommit;

  always_comb begin
    stb = '0;
    if (idxOk) begin
      unique case (hostOp)
        OP_LOCK:    stb.lockGo    = ~pinned;
        OP_UNLOCK:  stb.unlockGo  = selLock;
        OP_COMMIT:  stb.commitGo  = selLock;
        OP_CLRFULL: stb.clrFullGo = 1'b1;
        OP_CONFIG:  stb.cfgGo     = selLock;
        default:    stb = '0;
      endcase
    end
  end

  // A done only counts when the channel actually holds a grant.
  assign doneGo = txDone & grantValid;

endmodule

// File: rtl/sta_dpath.sv
module sta_dpath
  import sta_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int NUM_CH  = 2,
  parameter int SLOT_W  = 3,
  parameter int CYC_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  hostStb_t                stb,
  input  logic [IDX_W-1:0]        hostIdx,
  input  logic [SLOT_W-1:0]       cfgSlot,
  input  logic [CYC_W-1:0]        cfgCycBase,
  input  logic [CYC_W-1:0]        cfgCycMask,
  input  logic [NUM_CH-1:0]       cfgChan,
  input  logic                    cfgRepeat,
  input  logic                    slotStart,
  input  logic [SLOT_W-1:0]       slotNum,
  input  logic [CYC_W-1:0]        cycleCnt,
  input  logic [NUM_CH-1:0]       doneGo,
  output logic [NUM_CH-1:0]       grantValid,
  output logic [NUM_CH*IDX_W-1:0] grantIdx,
  output logic [NUM_BUF-1:0]      lockFlags,
  output logic [NUM_BUF-1:0]      commitFlags,
  output logic [NUM_BUF-1:0]      validFlags,
  output logic [NUM_BUF-1:0]      fullFlags
);

  // Per-buffer configuration
  logic [SLOT_W-1:0] slotId  [NUM_BUF];
  logic [CYC_W-1:0]  cycBase [NUM_BUF];
  logic [CYC_W-1:0]  cycMask [NUM_BUF];
  logic [NUM_CH-1:0] chanEn  [NUM_BUF];
  logic [NUM_BUF-1:0] repeatTx;

  // Per-buffer state
  logic [NUM_BUF-1:0] lockQ;
  logic [NUM_BUF-1:0] commitQ;
  logic [NUM_BUF-1:0] validQ;
  logic [NUM_BUF-1:0] fullQ;
  logic [NUM_BUF-1:0] doneHit;
  logic [NUM_BUF-1:0] hostSel;

  always_comb begin
    hostSel = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      hostSel[i] = (hostIdx == IDX_W'(i));
    end
  end

  // Configuration store, written only through an accepted command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repeatTx <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        slotId[i]  <= '0;
        cycBase[i] <= '0;
        cycMask[i] <= '0;
        chanEn[i]  <= '0;
      end
    end else if (stb.cfgGo) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (hostSel[i]) begin
          slotId[i]   <= cfgSlot;
          cycBase[i]  <= cfgCycBase;
          cycMask[i]  <= cfgCycMask;
          chanEn[i]   <= cfgChan;
          repeatTx[i] <= cfgRepeat;
        end
      end
    end
  end

  // Buffers hit by a done on any channel.
  always_comb begin
    doneHit = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (doneGo[c] && grantIdx[c*IDX_W +: IDX_W] == IDX_W'(i)) doneHit[i] = 1'b1;
      end
    end
  end

  // State flags: done effects first, host effects after, full set by done kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= '0;
      commitQ <= '0;
      validQ  <= '0;
      fullQ   <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (doneHit[i]) begin
          fullQ[i]   <= 1'b1;
          commitQ[i] <= 1'b0;
          if (!repeatTx[i]) validQ[i] <= 1'b0;
        end
        if (hostSel[i]) begin
          if (stb.lockGo) lockQ[i] <= 1'b1;
          if (stb.unlockGo) begin
            lockQ[i] <= 1'b0;
            if (commitQ[i]) validQ[i] <= 1'b1;
          end
          if (stb.commitGo) commitQ[i] <= 1'b1;
          if (stb.clrFullGo && !doneHit[i]) fullQ[i] <= 1'b0;
        end
      end
    end
  end

  // Per-channel candidate search and grant register.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [NUM_BUF-1:0] cand;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic               gValid;
    logic [IDX_W-1:0]   gIdx;

    always_comb begin
      for (int i = 0; i < NUM_BUF; i++) begin
        cand[i] = validQ[i] & ~lockQ[i] & chanEn[i][c]
                & (slotId[i] == slotNum)
                & (((cycleCnt ^ cycBase[i]) & cycMask[i]) == '0);
      end
    end

    sta_pick #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pick (
      .cand  (cand),
      .found (found),
      .pick  (pick)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gValid <= 1'b0;
        gIdx   <= '0;
      end else if (slotStart) begin
        gValid <= found;
        gIdx   <= pick;
      end else if (doneGo[c]) begin
        gValid <= 1'b0;
      end
    end

    assign grantValid[c]                = gValid;
    assign grantIdx[c*IDX_W +: IDX_W]   = gIdx;
  end

  assign lockFlags   = lockQ;
  assign commitFlags = commitQ;
  assign validFlags  = validQ;
  assign fullFlags   = fullQ;

endmodule

// File: rtl/slot_tx_arbiter.sv
module slot_tx_arbiter
  import sta_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int NUM_CH  = 2,
  parameter int SLOT_W  = 3,
  parameter int CYC_W   = 3,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              hostOp,
  input  logic [IDX_W-1:0]        hostIdx,
  input  logic [SLOT_W-1:0]       cfgSlot,
  input  logic [CYC_W-1:0]        cfgCycBase,
  input  logic [CYC_W-1:0]        cfgCycMask,
  input  logic [NUM_CH-1:0]       cfgChan,
  input  logic                    cfgRepeat,
  input  logic                    slotStart,
  input  logic [SLOT_W-1:0]       slotNum,
  input  logic [CYC_W-1:0]        cycleCnt,
  input  logic [NUM_CH-1:0]       txDone,
  output logic [NUM_CH-1:0]       grantValid,
  output logic [NUM_CH*IDX_W-1:0] grantIdx,
  output logic [NUM_BUF-1:0]      lockFlags,
  output logic [NUM_BUF-1:0]      commitFlags,
  output logic [NUM_BUF-1:0]      validFlags,
  output logic [NUM_BUF-1:0]      fullFlags
);

  hostStb_t          stb;
  logic [NUM_CH-1:0] doneGo;

  sta_ctrl #(.NUM_BUF(NUM_BUF), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .hostOp      (hostOp),
    .hostIdx     (hostIdx),
    .lockFlags   (lockFlags),
    .validFlags  (validFlags),
    .commitFlags (commitFlags),
    .grantValid  (grantValid),
    .txDone      (txDone),
    .stb         (stb),
    .doneGo      (doneGo)
  );

  sta_dpath #(
    .NUM_BUF(NUM_BUF), .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CYC_W(CYC_W), .IDX_W(IDX_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .hostIdx     (hostIdx),
    .cfgSlot     (cfgSlot),
    .cfgCycBase  (cfgCycBase),
    .cfgCycMask  (cfgCycMask),
    .cfgChan     (cfgChan),
    .cfgRepeat   (cfgRepeat),
    .slotStart   (slotStart),
    .slotNum     (slotNum),
    .cycleCnt    (cycleCnt),
    .doneGo      (doneGo),
    .grantValid  (grantValid),
    .grantIdx    (grantIdx),
    .lockFlags   (lockFlags),
    .commitFlags (commitFlags),
    .validFlags  (validFlags),
    .fullFlags   (fullFlags)
  );

endmodule

// File: rtl/sta_chk.sv
module sta_chk #(
  parameter int NUM_BUF = 4,
  parameter int NUM_CH  = 2,
  parameter int IDX_W   = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2:0]              hostOp,
  input logic [IDX_W-1:0]        hostIdx,
  input logic                    slotStart,
  input logic [NUM_CH-1:0]       txDone,
  input logic [NUM_CH-1:0]       grantValid,
  input logic [NUM_CH*IDX_W-1:0] grantIdx,
  input logic [NUM_BUF-1:0]      lockFlags,
  input logic [NUM_BUF-1:0]      commitFlags,
  input logic [NUM_BUF-1:0]      validFlags,
  input logic [NUM_BUF-1:0]      fullFlags
);

  logic [NUM_BUF-1:0]      vPrev;
  logic [NUM_BUF-1:0]      lPrev;
  logic [IDX_W-1:0]        hPrev;
  logic [NUM_CH*IDX_W-1:0] gPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPrev <= '0;
      lPrev <= '0;
      hPrev <= '0;
      gPrev <= '0;
    end else begin
      vPrev <= validFlags;
      lPrev <= lockFlags;
      hPrev <= hostIdx;
      gPrev <= grantIdx;
    end
  end

  // R5
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostOp == 3'd1 && 32'(hostIdx) < NUM_BUF && validFlags[hostIdx] &&
     commitFlags[hostIdx] && !lockFlags[hostIdx]) |=> !lockFlags[hPrev]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R1
    grant_src_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(slotStart) && grantValid[c]) |->
        (vPrev[grantIdx[c*IDX_W +: IDX_W]] && !lPrev[grantIdx[c*IDX_W +: IDX_W]]));
    // R7
    full_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grantValid[c] && txDone[c]) |=> fullFlags[gPrev[c*IDX_W +: IDX_W]]);
    // R4
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grantValid[c] && txDone[c] && !slotStart) |=> !grantValid[c]);
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    // R5
    commit_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(commitFlags[i]) |-> lPrev[i]);
  end

endmodule

bind slot_tx_arbiter sta_chk #(.NUM_BUF(NUM_BUF), .NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostOp      (hostOp),
  .hostIdx     (hostIdx),
  .slotStart   (slotStart),
  .txDone      (txDone),
  .grantValid  (grantValid),
  .grantIdx    (grantIdx),
  .lockFlags   (lockFlags),
  .commitFlags (commitFlags),
  .validFlags  (validFlags),
  .fullFlags   (fullFlags)
);

// File: tb/slot_tx_arbiter_bench.sv
module slot_tx_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NC = 2;
  localparam int SW = 3;
  localparam int CW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] hostOp = '0;
  logic [IW-1:0] hostIdx = '0;
  logic [SW-1:0] cfgSlot = '0;
  logic [CW-1:0] cfgCycBase = '0;
  logic [CW-1:0] cfgCycMask = '0;
  logic [NC-1:0] cfgChan = '0;
  logic cfgRepeat = 1'b0;
  logic slotStart = 1'b0;
  logic [SW-1:0] slotNum = '0;
  logic [CW-1:0] cycleCnt = '0;
  logic [NC-1:0] txDone = '0;
  logic [NC-1:0] grantValid;
  logic [NC*IW-1:0] grantIdx;
  logic [NB-1:0] lockFlags, commitFlags, validFlags, fullFlags;

  slot_tx_arbiter u_slot_tx_arbiter (
    .clk(clk), .rstN(rstN), .hostOp(hostOp), .hostIdx(hostIdx),
    .cfgSlot(cfgSlot), .cfgCycBase(cfgCycBase), .cfgCycMask(cfgCycMask),
    .cfgChan(cfgChan), .cfgRepeat(cfgRepeat), .slotStart(slotStart),
    .slotNum(slotNum), .cycleCnt(cycleCnt), .txDone(txDone),
    .grantValid(grantValid), .grantIdx(grantIdx), .lockFlags(lockFlags),
    .commitFlags(commitFlags), .validFlags(validFlags), .fullFlags(fullFlags)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model built from the requirements
  bit mL[NB], mC[NB], mV[NB], mF[NB], mT[NB];
  int mS[NB], mB[NB], mM[NB], mCh[NB];
  bit mGV[NC];
  int mGI[NC];

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag);
    logic [NB-1:0] eL, eC, eV, eF;
    for (int i = 0; i < NB; i++) begin
      eL[i] = mL[i]; eC[i] = mC[i]; eV[i] = mV[i]; eF[i] = mF[i];
    end
    chk(lockFlags == eL, {tag, " lock"}, int'(lockFlags), int'(eL));
    chk(commitFlags == eC, {tag, " commit"}, int'(commitFlags), int'(eC));
    chk(validFlags == eV, {tag, " valid"}, int'(validFlags), int'(eV));
    chk(fullFlags == eF, {tag, " full"}, int'(fullFlags), int'(eF));
  endtask

  // Host command and done strobes in one cycle; model applies done then host.
  task automatic step(input int op, input int idx, input logic [NC-1:0] dm);
    bit lockOk, holdsLock, preC;
    bit hit[NB];
    lockOk = !(mV[idx] && mC[idx]);
    holdsLock = mL[idx];
    preC = mC[idx];
    hostOp = 3'(op);
    hostIdx = IW'(idx);
    txDone = dm;
    tick();
    hostOp = '0;
    txDone = '0;
    for (int i = 0; i < NB; i++) hit[i] = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (dm[c] && mGV[c]) begin
        int h = mGI[c];
        mF[h] = 1'b1; mC[h] = 1'b0;
        if (!mT[h]) mV[h] = 1'b0;
        hit[h] = 1'b1;
        mGV[c] = 1'b0;
      end
    end
    case (op)
      1: if (lockOk) mL[idx] = 1'b1;
      2: if (holdsLock) begin mL[idx] = 1'b0; if (preC) mV[idx] = 1'b1; end
      3: if (holdsLock) mC[idx] = 1'b1;
      4: if (!hit[idx]) mF[idx] = 1'b0;
      5: if (holdsLock) begin
           mS[idx] = int'(cfgSlot); mB[idx] = int'(cfgCycBase);
           mM[idx] = int'(cfgCycMask); mCh[idx] = int'(cfgChan); mT[idx] = cfgRepeat;
         end
      default: ;
    endcase
  endtask

  task automatic writeCfg(input int idx, input int s, input int b, input int m,
                          input int ch, input bit t);
    cfgSlot = SW'(s); cfgCycBase = CW'(b); cfgCycMask = CW'(m);
    cfgChan = NC'(ch); cfgRepeat = t;
    step(5, idx, '0);
  endtask

  task automatic slotGo(input int s, input int cyc);
    slotStart = 1'b1; slotNum = SW'(s); cycleCnt = CW'(cyc);
    tick();
    slotStart = 1'b0;
    for (int c = 0; c < NC; c++) begin
      mGV[c] = 1'b0; mGI[c] = 0;
      for (int i = NB - 1; i >= 0; i--) begin
        if (mV[i] && !mL[i] && mS[i] == s && ((cyc & mM[i]) == (mB[i] & mM[i]))
            && mCh[i][c]) begin
          mGV[c] = 1'b1; mGI[c] = i;
        end
      end
    end
  endtask

  task automatic checkGrant(input string tag);
    for (int c = 0; c < NC; c++) begin
      chk(grantValid[c] == mGV[c], {tag, " R2 grantValid"}, int'(grantValid[c]), int'(mGV[c]));
      if (mGV[c])
        chk(int'(grantIdx[c*IW +: IW]) == mGI[c], {tag, " R3 grantIdx"},
            int'(grantIdx[c*IW +: IW]), mGI[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R4 actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mL[i] = 0; mC[i] = 0; mV[i] = 0; mF[i] = 0; mT[i] = 0;
      mS[i] = 0; mB[i] = 0; mM[i] = 0; mCh[i] = 0;
    end
    for (int c = 0; c < NC; c++) begin mGV[c] = 0; mGI[c] = 0; end
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R9 reset state
    checkFlags("R9 reset");
    chk(grantValid == '0, "R9 reset grant", int'(grantValid), 0);

    // Table: buf0 slot2 all cycles ch0 repeat; buf1 slot2 odd cycles ch1 repeat;
    // buf2 slot2 all cycles both ch single; buf3 slot5 cycle%4==2 both ch repeat
    for (int i = 0; i < NB; i++) begin
      step(1, i, '0);
      case (i)
        0: writeCfg(0, 2, 0, 0, 1, 1'b1);
        1: writeCfg(1, 2, 1, 1, 2, 1'b1);
        2: writeCfg(2, 2, 0, 0, 3, 1'b0);
        default: writeCfg(3, 5, 2, 3, 3, 1'b1);
      endcase
      step(3, i, '0);
      step(2, i, '0);
    end
    checkFlags("R6 commit then unlock");

    // R5: lock refused on committed valid buffer
    step(1, 0, '0);
    checkFlags("R5 lock refused");

    // Exhaustive sweep of slot and cycle
    for (int cyc = 0; cyc < (1 << CW); cyc++) begin
      for (int s = 0; s < (1 << SW); s++) begin
        logic [NC-1:0] dm;
        slotGo(s, cyc);
        checkGrant("sweep R1");
        for (int c = 0; c < NC; c++) dm[c] = mGV[c];
        step(0, 0, dm);
        checkFlags("sweep R7");
        chk(grantValid == '0, "sweep R4 drop", int'(grantValid), 0);
      end
    end

    // R5: relock allowed after send; unlock without commit keeps valid
    step(1, 0, '0);
    checkFlags("R5 relock after send");
    step(2, 0, '0);
    checkFlags("R6 unlock no commit");

    // R5: config write on an unlocked buffer is ignored
    cfgSlot = 3'd7; cfgCycBase = '0; cfgCycMask = '0; cfgChan = 2'b01; cfgRepeat = 1'b1;
    step(5, 2, '0);
    step(1, 2, '0);
    step(3, 2, '0);
    step(2, 2, '0);
    checkFlags("R5 recommit buf2");
    slotGo(2, 0);
    checkGrant("R5 cfg ignored unlocked");

    // R9 clear full
    step(4, 2, '0);
    checkFlags("R9 clear full");

    // R8: done and clear-full in the same cycle; full stays set
    step(4, 2, 2'b10);
    checkFlags("R8 done beats clear");

    // R8: done and host commit in same cycle; commit survives
    slotGo(2, 1);
    checkGrant("R8 setup");
    step(1, 1, '0);
    step(3, 1, 2'b10);
    checkFlags("R8 commit beats done");
    step(2, 1, '0);
    checkFlags("R6 unlock sets valid");
    step(1, 1, '0);
    checkFlags("R5 lock refused again");
    step(0, 0, 2'b01);
    checkFlags("R7 ch0 done");

    // R4: grant held without done, replaced at next slot start
    slotGo(5, 2);
    checkGrant("R4 both channels");
    tick(); tick();
    checkGrant("R4 hold");
    slotGo(0, 0);
    checkGrant("R4 empty slot");

    // R1: locked buffer excluded
    step(1, 0, '0);
    slotGo(2, 3);
    checkGrant("R1 locked excluded");
    step(2, 0, '0);
    step(0, 0, 2'b11);
    checkFlags("R1 cleanup");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule